// File: doc/BRIEF.md
# Multi-mode 8-bit PWM timer

An 8-bit timer with two waveform channels. A 3-bit mode field makes it a free-running counter, a counter that clears on a match with compare A, a single-slope PWM generator, or a dual-slope (phase-correct) PWM generator. In the PWM modes TOP is either fixed at 0xFF or taken from compare A. Each channel has a compare register and a 2-bit output-mode field. In the PWM modes the compare registers are double-buffered. The timer sets an overflow flag and two compare-match flags. A force strobe applies a channel's match action at once, but only in the non-PWM modes.

Software reaches the block through a register port with single-cycle writes and a combinational read. The counter moves only on clocks where the external `tick` input is high, so any prescaler sits outside the block. The only outputs are the two waveform bits and the three flags.

Top module: `pwm_timer8`

## Requirements
- R1: After reset the counter, both compare registers and their buffers, the mode field, both output-mode fields and all flags are zero. Both waveform outputs are low, and every register address reads back 0x00.
- R2: Mode codes: 000 normal, 010 CTC, 011 fast PWM with TOP=0xFF, 111 fast PWM with TOP=compare A; 100 and 110 behave as normal. In the normal, CTC and fast modes the counter steps up by one on each tick. On the tick where it equals TOP it goes to 0 instead; TOP is compare A in CTC. Without a tick the counter holds. A write to the count register loads it.
- R3: Mode codes 001 (TOP=0xFF) and 101 (TOP=compare A) are phase-correct. On each tick the counter rises to TOP and then falls to 0, turning around at each end.
- R4: In the non-PWM modes a write to a compare register takes effect in the next cycle. In the PWM modes the write goes to a buffer, and the compare register takes the buffer's value on the tick where the counter is at TOP: the turn-around in the phase-correct modes, the wrap to 0 in the fast modes. Reading a compare address returns the last value written.
- R5: Where the overflow flag sets depends on the mode. In the normal, CTC and reserved modes it sets on a tick with the counter at 0xFF. In the fast modes it sets on the tick at TOP. In the phase-correct modes it sets on the tick where the counter reaches 0 coming down.
- R6: A compare flag sets on a tick where the counter equals that channel's compare value. Flag bits are ovf=0, cmpA=1, cmpB=2 at address 5. Writing 1 to a bit clears it, and writing 0 leaves it alone. A set in the same cycle wins over a clear.
- R7: In the non-PWM modes a match acts on the output as set by the output mode: 01 toggles it, 10 clears it, 11 sets it. Output mode 00 drives the pin low.
- R8: In the fast modes, output mode 10 sets the output at the wrap from TOP and clears it on a match. Output mode 11 does the reverse. Output modes 00 and 01 drive the pin low.
- R9: In the phase-correct modes, output mode 10 clears the output on a match while the counter is rising and sets it on a match while it is falling. Output mode 11 does the reverse. The direction is the one the counter takes on that tick.
- R10: When a channel's compare value equals TOP in a fast mode, the match action is dropped and the TOP action is applied. So with output mode 10 the pin stays high.
- R11: Writing 1 to bit 7 (A) or bit 6 (B) of address 1 in a non-PWM mode applies that channel's match action in the next cycle. It does not set a flag and does not change the counter. In the PWM modes the strobe does nothing, and both strobe bits read back as 0.
- R12: Register map: address 0 = {outmode A[7:6], outmode B[5:4], reserved[3:2], mode[1:0]}; address 1 = {strobes[7:6], mode[2] at bit 3}; address 2 = counter; 3 and 4 = compare A and B; 5 = flags. Reserved bits and all other bits of address 1 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | W | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | W | Read data (combinational) |
| wave_a | output | 1 | Channel A waveform |
| wave_b | output | 1 | Channel B waveform |
| ovf_flag | output | 1 | Overflow flag |
| cmp_a_flag | output | 1 | Channel A compare flag |
| cmp_b_flag | output | 1 | Channel B compare flag |

## Verification
Every counter, flag and waveform result is due one clock after the tick or write that causes it, because each passes through exactly one register stage. Read data is combinational on the current state. The bench keeps a behavioural model that advances at each rising edge from the inputs the bench drove at the preceding falling edge. It compares the counter, all flags and both waveforms at every falling edge, so each result is checked in the first cycle it is due. Register reads are sampled within the cycle after the address settles and before the next edge.

// File: rtl/pwm_timer8.sv
`timescale 1ns/1ps
module pwm_timer8 #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         wr_en,
  input  logic [2:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  input  logic [2:0]   rd_addr,
  output logic [W-1:0] rd_data,
  output logic         wave_a,
  output logic         wave_b,
  output logic         ovf_flag,
  output logic         cmp_a_flag,
  output logic         cmp_b_flag
);
  localparam int RSV = W - 6;

  logic [W-1:0] cnt, ocr_a, ocr_b, buf_a, buf_b, top;
  logic [2:0]   mode;
  logic [1:0]   com_a, com_b;
  logic oc_a, oc_b, dir_up, ovf_q, cfa_q, cfb_q;
  logic non_pwm, fast, phase, at_top, at_bot, mv_up, wrap, upd;
  logic hit_a, hit_b, frc_a, frc_b, ovf_set, na, nb;
  logic wr_c0, wr_c1, wr_cnt, wr_oa, wr_ob, wr_flg;

  assign wr_c0  = wr_en && wr_addr == 3'd0;
  assign wr_c1  = wr_en && wr_addr == 3'd1;
  assign wr_cnt = wr_en && wr_addr == 3'd2;
  assign wr_oa  = wr_en && wr_addr == 3'd3;
  assign wr_ob  = wr_en && wr_addr == 3'd4;
  assign wr_flg = wr_en && wr_addr == 3'd5;

  assign non_pwm = ~mode[0];
  assign fast    = mode[1] & mode[0];
  assign phase   = ~mode[1] & mode[0];
  assign top     = (mode == 3'b010 || (mode[2] && mode[0])) ? ocr_a : '1;
  assign at_top  = cnt == top;
  assign at_bot  = cnt == '0;
  assign mv_up   = at_bot ? 1'b1 : (at_top ? 1'b0 : dir_up);
  assign wrap    = tick & at_top;
  assign upd     = ~non_pwm & wrap;
  assign hit_a   = tick & (cnt == ocr_a);
  assign hit_b   = tick & (cnt == ocr_b);
  assign frc_a   = wr_c1 & wr_data[W-1] & non_pwm;
  assign frc_b   = wr_c1 & wr_data[W-2] & non_pwm;
  assign ovf_set = tick & (phase ? (at_bot & ~dir_up) : (fast ? at_top : (cnt == '1)));

  function automatic logic wave_next(input logic cur, input logic [1:0] com,
                                     input logic hit, input logic frc,
                                     input logic np, input logic fs,
                                     input logic wr_top, input logic up);
    logic r;
    r = cur;
    if (np) begin
      if (hit || frc)
        case (com)
          2'b01:   r = ~cur;
          2'b10:   r = 1'b0;
          2'b11:   r = 1'b1;
          default: r = cur;
        endcase
    end else if (com[1]) begin
      if (fs) begin
        if (wr_top)   r = ~com[0];
        else if (hit) r = com[0];
      end else if (hit) begin
        r = up ? com[0] : ~com[0];
      end
    end
    return r;
  endfunction

  assign na = wave_next(oc_a, com_a, hit_a, frc_a, non_pwm, fast, wrap, mv_up);
  assign nb = wave_next(oc_b, com_b, hit_b, frc_b, non_pwm, fast, wrap, mv_up);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; dir_up <= 1'b1;
      ocr_a <= '0; ocr_b <= '0; buf_a <= '0; buf_b <= '0;
      mode <= '0; com_a <= '0; com_b <= '0;
      oc_a <= 1'b0; oc_b <= 1'b0;
      ovf_q <= 1'b0; cfa_q <= 1'b0; cfb_q <= 1'b0;
    end else begin
      if (wr_cnt)
        cnt <= wr_data;
      else if (tick)
        cnt <= phase ? (mv_up ? cnt + 1'b1 : cnt - 1'b1) : (at_top ? '0 : cnt + 1'b1);
      if (tick && phase) dir_up <= mv_up;

      if (wr_oa) buf_a <= wr_data;
      if (wr_ob) buf_b <= wr_data;
      if (non_pwm && wr_oa) ocr_a <= wr_data;
      else if (upd)         ocr_a <= buf_a;
      if (non_pwm && wr_ob) ocr_b <= wr_data;
      else if (upd)         ocr_b <= buf_b;

      oc_a <= na;
      oc_b <= nb;

      ovf_q <= ovf_set | (ovf_q & ~(wr_flg & wr_data[0]));
      cfa_q <= hit_a   | (cfa_q & ~(wr_flg & wr_data[1]));
      cfb_q <= hit_b   | (cfb_q & ~(wr_flg & wr_data[2]));

      if (wr_c0) begin
        com_a     <= wr_data[W-1:W-2];
        com_b     <= wr_data[W-3:W-4];
        mode[1:0] <= wr_data[1:0];
      end
      if (wr_c1) mode[2] <= wr_data[3];
    end
  end

  assign wave_a     = (com_a[1] | (non_pwm & com_a[0])) & oc_a;
  assign wave_b     = (com_b[1] | (non_pwm & com_b[0])) & oc_b;
  assign ovf_flag   = ovf_q;
  assign cmp_a_flag = cfa_q;
  assign cmp_b_flag = cfb_q;

  always_comb begin
    case (rd_addr)
      3'd0:    rd_data = {com_a, com_b, {RSV{1'b0}}, mode[1:0]};
      3'd1:    rd_data = {{(W-4){1'b0}}, mode[2], 3'b000};
      3'd2:    rd_data = cnt;
      3'd3:    rd_data = buf_a;
      3'd4:    rd_data = buf_b;
      3'd5:    rd_data = {{(W-3){1'b0}}, cfb_q, cfa_q, ovf_q};
      default: rd_data = '0;
    endcase
  end

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_cnt) |=> $stable(cnt));
  p_ctc_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && mode == 3'b010 && cnt == ocr_a && !wr_cnt) |=> cnt == '0);
  p_phase_turn_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && phase && at_top && !at_bot && !wr_cnt) |=> cnt == $past(cnt) - 1'b1);
  p_ovf_phase_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && phase && !at_bot && !ovf_q) |=> !ovf_flag);
  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && wr_flg && wr_data[0]) |=> !ovf_flag);
  p_top_b_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && fast && com_b == 2'b10 && at_top && ocr_b == top && !wr_c0) |=> wave_b);
  p_force_noflag_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_c1 && wr_data[W-1] && !tick && !cfa_q) |=> !cmp_a_flag);
  p_pwm_force_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_c1 && mode[0] && !tick) |=> $stable(oc_a));
endmodule

// File: tb/tb_pwm_timer8.sv
`timescale 1ns/1ps
module tb_pwm_timer8;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, wr_en = 1'b0;
  logic [2:0] wr_addr = '0, rd_addr = 3'd2;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic wave_a, wave_b, ovf_flag, cmp_a_flag, cmp_b_flag;

  int checks = 0, fails = 0;
  bit done = 0;
  string stage = "R1";

  pwm_timer8 #(.W(8)) dut (.clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .wave_a(wave_a), .wave_b(wave_b), .ovf_flag(ovf_flag),
    .cmp_a_flag(cmp_a_flag), .cmp_b_flag(cmp_b_flag));

  always #2.5 clk = ~clk;

  // behavioural reference
  int m_cnt, m_up, m_ocra, m_ocrb, m_bufa, m_bufb, m_mode, m_coma, m_comb, m_oa, m_ob;
  int m_ovf, m_cfa, m_cfb;

  function automatic int kind_of(int md);
    if (md == 1 || md == 5) return 2;   // dual slope
    if (md == 3 || md == 7) return 1;   // single slope
    return 0;
  endfunction

  function automatic int act(int cur, int com, int k, bit hit, bit frc, bit at_t, bit up);
    if (k == 0) begin
      if (!(hit || frc)) return cur;
      if (com == 1) return 1 - cur;
      if (com == 2) return 0;
      if (com == 3) return 1;
      return cur;
    end
    if (com < 2) return cur;
    if (k == 1) begin
      if (at_t) return (com == 2) ? 1 : 0;
      if (hit)  return (com == 3) ? 1 : 0;
      return cur;
    end
    if (!hit) return cur;
    if (up) return (com == 3) ? 1 : 0;
    return (com == 2) ? 1 : 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_up = 1; m_ocra = 0; m_ocrb = 0; m_bufa = 0; m_bufb = 0;
      m_mode = 0; m_coma = 0; m_comb = 0; m_oa = 0; m_ob = 0;
      m_ovf = 0; m_cfa = 0; m_cfb = 0;
    end else begin
      int k, t, n_cnt, n_ocra, n_ocrb;
      bit up, at_t, ha, hb, fa, fb, os, wa, wb, wf;
      k = kind_of(m_mode);
      t = (m_mode == 2 || m_mode == 5 || m_mode == 7) ? m_ocra : 255;
      up = (m_cnt == 0) ? 1 : ((m_cnt == t) ? 0 : (m_up != 0));
      at_t = tick && m_cnt == t;
      ha = tick && m_cnt == m_ocra;
      hb = tick && m_cnt == m_ocrb;
      fa = wr_en && wr_addr == 1 && wr_data[7] && k == 0;
      fb = wr_en && wr_addr == 1 && wr_data[6] && k == 0;
      wa = wr_en && wr_addr == 3;
      wb = wr_en && wr_addr == 4;
      wf = wr_en && wr_addr == 5;
      if (k == 2)      os = tick && m_cnt == 0 && m_up == 0;
      else if (k == 1) os = at_t;
      else             os = tick && m_cnt == 255;
      n_cnt = m_cnt;
      if (wr_en && wr_addr == 2) n_cnt = wr_data;
      else if (tick) begin
        if (k == 2) n_cnt = up ? (m_cnt + 1) % 256 : (m_cnt + 255) % 256;
        else        n_cnt = (m_cnt == t) ? 0 : (m_cnt + 1) % 256;
      end
      n_ocra = (k == 0 && wa) ? int'(wr_data) : ((k != 0 && at_t) ? m_bufa : m_ocra);
      n_ocrb = (k == 0 && wb) ? int'(wr_data) : ((k != 0 && at_t) ? m_bufb : m_ocrb);
      m_oa = act(m_oa, m_coma, k, ha, fa, at_t, up);
      m_ob = act(m_ob, m_comb, k, hb, fb, at_t, up);
      m_ovf = (os || (m_ovf != 0 && !(wf && wr_data[0]))) ? 1 : 0;
      m_cfa = (ha || (m_cfa != 0 && !(wf && wr_data[1]))) ? 1 : 0;
      m_cfb = (hb || (m_cfb != 0 && !(wf && wr_data[2]))) ? 1 : 0;
      if (tick && k == 2) m_up = up;
      if (wa) m_bufa = wr_data;
      if (wb) m_bufb = wr_data;
      m_ocra = n_ocra; m_ocrb = n_ocrb; m_cnt = n_cnt;
      if (wr_en && wr_addr == 0) begin
        m_coma = wr_data[7:6]; m_comb = wr_data[5:4];
        m_mode = (m_mode & 4) | wr_data[1:0];
      end
      if (wr_en && wr_addr == 1) m_mode = (m_mode & 3) | (wr_data[3] ? 4 : 0);
    end
  end

  task automatic cmp(input string req, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s [%s] %s: got %0d expected %0d at %0t", req, stage, what, got, exp, $time);
    end
  endtask

  always @(negedge clk) if (!done) begin
    int k, pa, pb;
    string wreq;
    k = kind_of(m_mode);
    wreq = (k == 0) ? "R7" : ((k == 1) ? "R8" : "R9");
    pa = (m_coma >= 2 || (k == 0 && m_coma == 1)) ? m_oa : 0;
    pb = (m_comb >= 2 || (k == 0 && m_comb == 1)) ? m_ob : 0;
    cmp((k == 2) ? "R3" : "R2", "counter", int'(rd_data), m_cnt);
    cmp("R5", "ovf_flag", int'(ovf_flag), m_ovf);
    cmp("R6", "cmp_a_flag", int'(cmp_a_flag), m_cfa);
    cmp("R6", "cmp_b_flag", int'(cmp_b_flag), m_cfb);
    cmp(wreq, "wave_a", int'(wave_a), pa);
    cmp(wreq, "wave_b", int'(wave_b), pb);
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    #0.2; wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    #0.2; wr_en = 1'b0;
  endtask

  task automatic run(input int n, input bit gaps);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #0.2; tick = gaps ? (i % 3 != 0) : 1'b1;
    end
    @(negedge clk);
    #0.2; tick = 1'b0;
  endtask

  task automatic rdchk(input logic [2:0] a, input int exp, input string req);
    @(negedge clk);
    #0.5; rd_addr = a;
    #0.5; cmp(req, "read", int'(rd_data), exp);
    rd_addr = 3'd2;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    stage = "R1";
    for (int a = 0; a < 6; a++) rdchk(3'(a), 0, "R1");

    stage = "R7";                       // normal mode, toggle A, set B
    wr(3, 8'd10); wr(4, 8'd20);
    rdchk(3, 10, "R4");
    wr(0, 8'h70);
    run(600, 1);
    wr(0, 8'h60);
    run(300, 0);

    stage = "R2";                       // CTC on compare A
    wr(3, 8'd15);
    wr(0, 8'h62);
    run(150, 0);
    wr(2, 8'd200);
    run(100, 1);

    stage = "R11";                      // force strobes, non-PWM
    wr(0, 8'h70);
    wr(5, 8'h07);
    wr(1, 8'h80);
    wr(1, 8'h40);
    wr(1, 8'h80);
    rdchk(1, 0, "R11");
    rdchk(5, 0, "R11");

    stage = "R6";
    run(30, 0);
    wr(5, 8'h02);
    wr(5, 8'h00);
    wr(5, 8'h07);
    rdchk(5, 0, "R6");

    stage = "R8";                       // fast PWM, TOP=0xFF
    wr(3, 8'd40); wr(4, 8'd200);
    wr(0, 8'hB3);
    wr(1, 8'h80);                       // strobe ignored in PWM (R11)
    run(300, 0);
    stage = "R4";
    wr(3, 8'd100);
    rdchk(3, 100, "R4");
    run(600, 1);

    stage = "R10";                      // fast PWM, TOP=compare A, B at TOP
    wr(0, 8'hA0);
    wr(3, 8'd50); wr(4, 8'd50);
    wr(1, 8'h08);
    wr(0, 8'hA3);
    run(120, 0);
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      #0.2; tick = 1'b1;
      #0.5; cmp("R10", "wave_b held", int'(wave_b), 1);
    end
    @(negedge clk); #0.2; tick = 1'b0;

    stage = "R9";                       // phase correct, TOP=0xFF
    wr(1, 8'h00);
    wr(0, 8'h00);
    wr(3, 8'd60); wr(4, 8'd180);
    wr(0, 8'hB1);
    run(1100, 0);
    stage = "R3";
    run(300, 1);

    stage = "R4";                       // phase correct, TOP=compare A
    wr(0, 8'h00);
    wr(3, 8'd30); wr(4, 8'd10);
    wr(1, 8'h08);
    wr(0, 8'hB1);
    run(400, 0);
    wr(3, 8'd40);
    run(300, 0);

    stage = "R12";
    wr(0, 8'hFF);
    rdchk(0, 8'hF3, "R12");
    rdchk(1, 8'h08, "R12");
    rdchk(6, 0, "R12");
    run(40, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule